// File: doc/BRIEF.md
# Gate-Drive Chopping Modulator

This block sits between a three-phase PWM timing generator and the gate-drive pins of a power stage. Some stages drive their switches through small pulse transformers, and a transformer cannot carry a steady level, so the on-time of each switch has to be broken up by a fast carrier. The block takes three high-side and three low-side PWM signals. While an output is asking for its device to be on (logic 1), it can replace that level with a square-wave carrier.

A 10-bit control register sets the carrier rate and turns chopping on or off. The high-side group and the low-side group are enabled independently. The carrier comes from a counter that divides the system clock, and that counter restarts on every register write. The register is meant to be written once, before the PWM generator starts, and left alone afterwards. After reset every control bit is clear, so all six signals pass straight through. PWM inputs are active high: 1 means "device on".

Top module: `gate_chop_modulator`

## Requirements
- R1: Reset clears the control register, which disables chopping in both groups. With reset released and no write made, each output equals its input.
- R2: When `cfg_we` is high at a rising clock edge, the control register loads `cfg_wdata`. Field layout: bits 7:0 hold the divider D (0 to 255), bit 8 enables high-side chopping and bit 9 enables low-side chopping.
- R3: The carrier is a square wave with 50% duty and a period of 4×(D+1) clocks. Counting k edges after the write edge (k = 0 is the state just after that edge), the carrier is 1 when floor(k / (2×(D+1))) is even and 0 when it is odd.
- R4: Every write restarts the carrier phase. Right after the write edge the carrier is 1 and the count is zero, whatever phase it had before.
- R5: With bit 8 set, each high-side output equals its input ANDed with the carrier.
- R6: With bit 9 set, each low-side output equals its input ANDed with the carrier.
- R7: A group whose enable bit is clear passes its three inputs through unchanged, whatever the other group's setting.
- R8: An inactive input (0) always gives an inactive output, whatever the configuration and carrier phase.
- R9: The divider limits hold. D = 0 gives a 4-clock period (2 clocks high, 2 clocks low). D = 255 gives a 1024-clock period (512 high, 512 low).
- R10: `cfg_wdata` has no effect while `cfg_we` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 10 | Control write data: [7:0] divider, [8] high-side enable, [9] low-side enable |
| pwm_hi_i | input | 3 | High-side PWM inputs, 1 = device on |
| pwm_lo_i | input | 3 | Low-side PWM inputs, 1 = device on |
| gate_hi_o | output | 3 | High-side gate-drive outputs |
| gate_lo_o | output | 3 | Low-side gate-drive outputs |

## Verification
A wrong divider or an off-by-one in the counter changes how long the carrier stays high. At a chopped output this shows as a wrong edge no later than the first half-period after a write, which is 2 clocks at D = 0 and 512 clocks at D = 255. A counter that misses its restart leaves the carrier in a phase it should not be in. This is visible at an enabled active output in the very first cycle after the write. A wrongly loaded enable bit, or a write that should have been ignored, shows within one carrier period. The affected group either stops following its inputs or fails to chop them.

// File: rtl/gdc_pkg.sv
`timescale 1ns/1ps
package gdc_pkg;
  localparam int DIV_W   = 8;
  localparam int CNT_W   = DIV_W + 1;
  localparam int CFG_W   = DIV_W + 2;
  localparam int PHASES  = 3;

  // Control word layout: {lo_en, hi_en, div}
  typedef struct packed {
    logic             lo_en;
    logic             hi_en;
    logic [DIV_W-1:0] div;
  } gdc_cfg_t;

  // Last count value of one half period: 2*(div+1)-1 = 2*div+1
  function automatic logic [CNT_W-1:0] half_last(input logic [DIV_W-1:0] div);
    return {div, 1'b1};
  endfunction

  // Gate-drive value for one lane
  function automatic logic gate_val(input logic pwm, input logic en, input logic carrier);
    return pwm & (carrier | ~en);
  endfunction
endpackage

// File: rtl/gdc_cfg_reg.sv
`timescale 1ns/1ps
module gdc_cfg_reg
  import gdc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  output gdc_cfg_t         cfg
);
  gdc_cfg_t cfg_q;

  always_ff @(posedge clk) begin
    if (!rst_n)  cfg_q <= '0;
    else if (we) cfg_q <= gdc_cfg_t'(wdata);
  end

  assign cfg = cfg_q;

  // R10: without a strobe the register holds its value
  assert_hold_without_we_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(cfg_q));
  // R2: a write is visible on the next cycle
  assert_write_loads_R2: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (cfg_q == gdc_cfg_t'($past(wdata))));
endmodule

// File: rtl/gdc_carrier.sv
`timescale 1ns/1ps
module gdc_carrier
  import gdc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [DIV_W-1:0] div,
  output logic             carrier,
  output logic             wrap
);
  logic [CNT_W-1:0] cnt_q;
  logic             car_q;
  logic [CNT_W-1:0] last;

  assign last = half_last(div);
  assign wrap = (cnt_q == last) && !restart;

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      cnt_q <= '0;
      car_q <= 1'b1;
    end else if (wrap) begin
      cnt_q <= '0;
      car_q <= ~car_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign carrier = car_q;

  // R3: the count never passes the end of a half period
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= last);
  // R3: the carrier only moves at a half-period boundary or a restart
  assert_stable_mid_half_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!wrap && !restart) |=> $stable(car_q));
  // R3: a boundary flips the carrier
  assert_toggle_on_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (car_q != $past(car_q)));
  // R4: a restart leaves the carrier high at count zero
  assert_restart_phase_R4: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (car_q && cnt_q == '0));
endmodule

// File: rtl/gdc_chop_group.sv
`timescale 1ns/1ps
module gdc_chop_group
  import gdc_pkg::*;
#(
  parameter int N = PHASES
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         carrier,
  input  logic [N-1:0] pwm_i,
  output logic [N-1:0] gate_o
);
  for (genvar p = 0; p < N; p++) begin : g_lane
    assign gate_o[p] = gate_val(pwm_i[p], en, carrier);
  end

  // R7: a disabled group passes through
  assert_passthru_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (gate_o == pwm_i));
  // R8: an inactive input never drives an active output
  assert_inactive_stays_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_o & ~pwm_i) == '0);
  // R5: an enabled group is dark while the carrier is low
  assert_dark_on_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !carrier) |-> (gate_o == '0));
endmodule

// File: rtl/gate_chop_modulator.sv
`timescale 1ns/1ps
module gate_chop_modulator
  import gdc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic [PHASES-1:0] pwm_hi_i,
  input  logic [PHASES-1:0] pwm_lo_i,
  output logic [PHASES-1:0] gate_hi_o,
  output logic [PHASES-1:0] gate_lo_o
);
  gdc_cfg_t cfg;
  logic     carrier;
  logic     carrier_wrap;

  gdc_cfg_reg u_cfg (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cfg_we),
    .wdata (cfg_wdata),
    .cfg   (cfg)
  );

  gdc_carrier u_car (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (cfg_we),
    .div     (cfg.div),
    .carrier (carrier),
    .wrap    (carrier_wrap)
  );

  gdc_chop_group #(.N(PHASES)) u_hi (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (cfg.hi_en),
    .carrier (carrier),
    .pwm_i   (pwm_hi_i),
    .gate_o  (gate_hi_o)
  );

  gdc_chop_group #(.N(PHASES)) u_lo (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (cfg.lo_en),
    .carrier (carrier),
    .pwm_i   (pwm_lo_i),
    .gate_o  (gate_lo_o)
  );

  // R1: the cycle after reset has no chopping in either group
  assert_reset_clear_R1: assert property (@(posedge clk)
    (!rst_n && !cfg_we) |=> (!cfg.hi_en && !cfg.lo_en && cfg.div == '0));
  // R6: the low group follows the carrier while enabled and active
  assert_lo_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg.lo_en |-> (gate_lo_o == (pwm_lo_i & {PHASES{carrier}})));
endmodule

// File: tb/gate_chop_modulator_tb.sv
`timescale 1ns/1ps
module gate_chop_modulator_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [9:0] cfg_wdata = '0;
  logic [2:0] pwm_hi_i = '0;
  logic [2:0] pwm_lo_i = '0;
  logic [2:0] gate_hi_o, gate_lo_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  gate_chop_modulator u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .pwm_hi_i(pwm_hi_i), .pwm_lo_i(pwm_lo_i),
    .gate_hi_o(gate_hi_o), .gate_lo_o(gate_lo_o)
  );

  typedef struct packed {
    logic [3:0]  req;
    logic [7:0]  div;
    logic        hen;
    logic        len;
    logic [2:0]  hi;
    logic [2:0]  lo;
    logic [11:0] k;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{4'd5, 8'd0,   1'b1, 1'b0, 3'b111, 3'b101, 12'd0},
    '{4'd5, 8'd0,   1'b1, 1'b0, 3'b111, 3'b101, 12'd2},
    '{4'd6, 8'd0,   1'b0, 1'b1, 3'b110, 3'b111, 12'd3},
    '{4'd9, 8'd0,   1'b0, 1'b1, 3'b110, 3'b111, 12'd4},
    '{4'd3, 8'd3,   1'b1, 1'b1, 3'b101, 3'b010, 12'd7},
    '{4'd3, 8'd3,   1'b1, 1'b1, 3'b101, 3'b010, 12'd8},
    '{4'd3, 8'd3,   1'b1, 1'b1, 3'b101, 3'b010, 12'd16},
    '{4'd9, 8'd255, 1'b1, 1'b1, 3'b111, 3'b111, 12'd511},
    '{4'd9, 8'd255, 1'b1, 1'b1, 3'b111, 3'b111, 12'd512},
    '{4'd9, 8'd255, 1'b1, 1'b1, 3'b111, 3'b111, 12'd1024},
    '{4'd8, 8'd5,   1'b1, 1'b1, 3'b000, 3'b000, 12'd3},
    '{4'd8, 8'd5,   1'b1, 1'b1, 3'b010, 3'b000, 12'd12},
    '{4'd7, 8'd7,   1'b0, 1'b0, 3'b011, 3'b100, 12'd20},
    '{4'd2, 8'd200, 1'b0, 1'b1, 3'b001, 3'b110, 12'd300}
  };

  function automatic string tag(input logic [3:0] r);
    case (r)
      4'd1: return "R1";  4'd2: return "R2";  4'd3: return "R3";
      4'd4: return "R4";  4'd5: return "R5";  4'd6: return "R6";
      4'd7: return "R7";  4'd8: return "R8";  4'd9: return "R9";
      default: return "R10";
    endcase
  endfunction

  // Carrier level k edges after a write: high in even half-periods
  function automatic logic exp_car(input int div, input int k);
    int half;
    half = 2 * (div + 1);
    return ((k / half) % 2) == 0;
  endfunction

  function automatic logic [2:0] exp_gate(input logic [2:0] pwm, input logic en, input logic car);
    if (!en) return pwm;
    return car ? pwm : 3'b000;
  endfunction

  task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic write_cfg(input logic [9:0] d);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_wdata = d;
    @(posedge clk);
    #1 cfg_we = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic car;
    pwm_hi_i = 3'b111;
    pwm_lo_i = 3'b111;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: after reset, pass-through in both groups over a full fast period
    for (int c = 0; c < 6; c++) begin
      @(negedge clk);
      check("R1", gate_hi_o, 3'b111, "reset hi");
      check("R1", gate_lo_o, 3'b111, "reset lo");
    end

    // R10: data with both enables and D=0 presented without strobe
    cfg_wdata = {1'b1, 1'b1, 8'd0};
    for (int c = 0; c < 6; c++) begin
      @(negedge clk);
      check("R10", gate_hi_o, 3'b111, "no-strobe hi");
      check("R10", gate_lo_o, 3'b111, "no-strobe lo");
    end

    // Vector table: write, wait k edges, sample
    for (int i = 0; i < NV; i++) begin
      pwm_hi_i = VECS[i].hi;
      pwm_lo_i = VECS[i].lo;
      write_cfg({VECS[i].len, VECS[i].hen, VECS[i].div});
      repeat (int'(VECS[i].k)) @(posedge clk);
      @(negedge clk);
      car = exp_car(int'(VECS[i].div), int'(VECS[i].k));
      check(tag(VECS[i].req), gate_hi_o, exp_gate(VECS[i].hi, VECS[i].hen, car), "vector hi");
      check(tag(VECS[i].req), gate_lo_o, exp_gate(VECS[i].lo, VECS[i].len, car), "vector lo");
    end

    // R9: cycle-by-cycle walk of D=0 over two periods, high side only
    pwm_hi_i = 3'b111;
    pwm_lo_i = 3'b111;
    write_cfg({1'b0, 1'b1, 8'd0});
    for (int k = 0; k < 8; k++) begin
      if (k > 0) @(posedge clk);
      @(negedge clk);
      check("R9", gate_hi_o, exp_car(0, k) ? 3'b111 : 3'b000, "D=0 walk");
      check("R7", gate_lo_o, 3'b111, "low group untouched");
    end

    // R4: rewrite while the carrier is low brings it straight back high
    write_cfg({1'b1, 1'b1, 8'd3});
    repeat (10) @(posedge clk);
    @(negedge clk);
    check("R4", gate_hi_o, 3'b000, "before restart (low half)");
    write_cfg({1'b1, 1'b1, 8'd3});
    @(negedge clk);
    check("R4", gate_hi_o, 3'b111, "right after restart");
    repeat (8) @(posedge clk);
    @(negedge clk);
    check("R4", gate_lo_o, 3'b000, "half period after restart");

    // R10: strobe low while data toggles, config stays D=3 both enabled
    cfg_wdata = 10'd0;
    write_cfg({1'b1, 1'b1, 8'd3});
    cfg_wdata = {1'b0, 1'b0, 8'd255};
    repeat (8) @(posedge clk);
    @(negedge clk);
    check("R10", gate_hi_o, 3'b000, "data ignored, still chopping");

    // R1: reset in mid-run returns to pass-through
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk) rst_n = 1'b1;
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      check("R1", gate_hi_o, 3'b111, "re-reset hi");
      check("R1", gate_lo_o, 3'b111, "re-reset lo");
    end

    finish_run();
  end
endmodule